// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block is the in-order retirement stage of a speculative out-of-order core. At issue an instruction takes the next free slot of a circular buffer. The slot number is handed back as the tag that the execution units attach to their result broadcast. Each slot records four things:

- the kind of instruction,
- where its result goes (a register number, or a memory address for a store),
- the result value,
- whether execution has finished.

A finished result stays in its slot until it reaches the oldest position. In the meantime, later instructions can look it up by tag as an operand source.

Retirement happens only at the oldest slot, one slot per cycle, and only once that slot holds a finished result. A register operation is sent to the register file. A store is sent to memory, using the address recorded at issue and the data from the broadcast. A correctly predicted branch simply leaves. A mispredicted branch, or any instruction that recorded an exception, empties the whole buffer instead and redirects fetch. Because none of this happens before the instruction is the oldest, exceptions stay precise.

Top module: `reorder_buffer`

## Requirements
- R1: Slot tags are handed out in sequence starting at 0 and wrap modulo DEPTH. `alloc_tag` always shows the tag the next accepted allocation will receive. After a flush, numbering restarts at 0.
- R2: When DEPTH slots are occupied, `alloc_ready` is low and an asserted `alloc_valid` is not accepted.
- R3: A broadcast with `wb_valid` writes `wb_value`, the exception flag and the mispredict flag into the live slot named by `wb_tag`, and marks that slot finished. For a store, the value written is the data to store.
- R4: Only the oldest slot retires, at most one per cycle, and its commit outputs pulse exactly one cycle after the edge at which it was both oldest and finished. A finished younger slot waits behind an unfinished older one.
- R5: Kind codes are 0 register op, 1 store, 2 branch, 3 no destination. Every normal retirement pulses `commit_retire`. Kind 0 also pulses `commit_reg_we`, and kind 1 pulses `commit_mem_we`. Both carry `commit_dest` equal to the recorded destination and `commit_data` equal to the result value. Kinds 2 and 3 write nothing.
- R6: A finished branch at the head flagged mispredicted produces a one-cycle `flush` with `flush_exc` = 0 and `redirect_pc` equal to its value field. It writes nothing, and it empties the buffer.
- R7: A finished slot at the head whose exception flag is set, of any kind, produces a `flush` with `flush_exc` = 1 and `redirect_pc` equal to its value field. It writes nothing, and it empties the buffer.
- R8: In the cycle in which a flush is being decided, `alloc_ready` is low and no allocation is accepted.
- R9: Lookup is registered. One cycle after `lk_tag` is presented, `lk_ready` is 1 and `lk_value` holds the value if that slot was live and finished; otherwise `lk_ready` is 0.
- R10: After reset the buffer is empty, `alloc_ready` is 1, `alloc_tag` is 0, and no commit, flush or lookup hit is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request a slot for an issuing instruction |
| alloc_kind | input | 2 | Kind code of the issuing instruction |
| alloc_dest | input | DEST_W | Register number or store address |
| alloc_ready | output | 1 | A slot can be accepted this cycle |
| alloc_tag | output | TAG_W | Tag the next accepted slot receives |
| wb_valid | input | 1 | Result broadcast present |
| wb_tag | input | TAG_W | Slot the broadcast belongs to |
| wb_value | input | DATA_W | Result, store data or branch target |
| wb_exc | input | 1 | Instruction raised an exception |
| wb_mispred | input | 1 | Branch was mispredicted |
| lk_tag | input | TAG_W | Slot to read as an operand |
| lk_ready | output | 1 | Looked-up slot was live and finished |
| lk_value | output | DATA_W | Looked-up value |
| commit_reg_we | output | 1 | Register file write strobe |
| commit_mem_we | output | 1 | Memory write strobe |
| commit_retire | output | 1 | A slot retired normally |
| commit_dest | output | DEST_W | Register number or memory address |
| commit_data | output | DATA_W | Data to write |
| flush | output | 1 | Buffer emptied, fetch redirected |
| flush_exc | output | 1 | Flush was caused by an exception |
| redirect_pc | output | DATA_W | Fetch restart address |

## Verification
The assertions assume that a broadcast only names a slot that is currently live and not yet finished, and that DEPTH is a power of two. The bench enforces this: it keeps its own record of live slots and picks broadcast tags only from those not yet finished. It does keep raising `alloc_valid` while the buffer is full or a flush is pending, because refusing those requests is part of the checked behaviour. Exceptions and mispredictions are injected at low rates, so that long runs of in-order retirement occur between flushes.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_REG    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2,
    K_NONE   = 2'd3
  } kind_e;
endpackage

// File: rtl/rob_ptrs.sv
// Head/tail pointers with one extra wrap bit so full and empty differ.
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OCC_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             clear,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [OCC_W-1:0] occ,
  output logic             full
);
  logic [OCC_W-1:0] head_q, tail_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign occ      = tail_q - head_q;
  assign full     = (head_idx == tail_idx) && (head_q[IDX_W] != tail_q[IDX_W]);
endmodule

// File: rtl/rob_entries.sv
// Slot storage: wide fields in plain arrays, status bits in flop vectors.
module rob_entries
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              alloc_we,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  kind_e             alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              wb_we,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_value,
  input  logic              wb_exc,
  input  logic              wb_mis,
  input  logic              pop,
  input  logic [IDX_W-1:0]  head_idx,
  output logic              h_live,
  output logic              h_done,
  output kind_e             h_kind,
  output logic [DEST_W-1:0] h_dest,
  output logic [DATA_W-1:0] h_value,
  output logic              h_exc,
  output logic              h_mis,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_ready_q,
  output logic [DATA_W-1:0] lk_value_q
);
  logic [DATA_W-1:0] val_mem  [DEPTH];
  logic [DEST_W-1:0] dest_mem [DEPTH];
  kind_e             kind_mem [DEPTH];
  logic [DEPTH-1:0]  live, done, exc, mis;
  logic              wb_hit;

  assign wb_hit = wb_we && live[wb_idx];

  always_ff @(posedge clk) begin
    if (alloc_we) begin
      dest_mem[alloc_idx] <= alloc_dest;
      kind_mem[alloc_idx] <= alloc_kind;
    end
    if (wb_hit) val_mem[wb_idx] <= wb_value;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      live <= '0;
      done <= '0;
      exc  <= '0;
      mis  <= '0;
    end else begin
      if (alloc_we) begin
        live[alloc_idx] <= 1'b1;
        done[alloc_idx] <= 1'b0;
        exc[alloc_idx]  <= 1'b0;
        mis[alloc_idx]  <= 1'b0;
      end
      if (wb_hit) begin
        done[wb_idx] <= 1'b1;
        exc[wb_idx]  <= wb_exc;
        mis[wb_idx]  <= wb_mis;
      end
      if (pop) begin
        live[head_idx] <= 1'b0;
        done[head_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_ready_q <= 1'b0;
      lk_value_q <= '0;
    end else begin
      lk_ready_q <= live[lk_idx] && done[lk_idx];
      lk_value_q <= val_mem[lk_idx];
    end
  end

  assign h_live  = live[head_idx];
  assign h_done  = done[head_idx];
  assign h_kind  = kind_mem[head_idx];
  assign h_dest  = dest_mem[head_idx];
  assign h_value = val_mem[head_idx];
  assign h_exc   = exc[head_idx];
  assign h_mis   = mis[head_idx];
endmodule

// File: rtl/rob_retire.sv
// Decides retire or flush for the oldest slot and registers the outputs.
module rob_retire
  import rob_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEST_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_live,
  input  logic              h_done,
  input  kind_e             h_kind,
  input  logic [DEST_W-1:0] h_dest,
  input  logic [DATA_W-1:0] h_value,
  input  logic              h_exc,
  input  logic              h_mis,
  output logic              pop,
  output logic              clear,
  output logic              reg_we_q,
  output logic              mem_we_q,
  output logic              retire_q,
  output logic [DEST_W-1:0] dest_q,
  output logic [DATA_W-1:0] data_q,
  output logic              flush_q,
  output logic              flush_exc_q,
  output logic [DATA_W-1:0] redirect_q
);
  logic go, bad;

  assign go    = h_live && h_done;
  assign bad   = go && (h_exc || (h_kind == K_BRANCH && h_mis));
  assign pop   = go && !bad;
  assign clear = bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_we_q    <= 1'b0;
      mem_we_q    <= 1'b0;
      retire_q    <= 1'b0;
      flush_q     <= 1'b0;
      flush_exc_q <= 1'b0;
      dest_q      <= '0;
      data_q      <= '0;
      redirect_q  <= '0;
    end else begin
      reg_we_q    <= pop && (h_kind == K_REG);
      mem_we_q    <= pop && (h_kind == K_STORE);
      retire_q    <= pop;
      flush_q     <= bad;
      flush_exc_q <= bad && h_exc;
      dest_q      <= h_dest;
      data_q      <= h_value;
      redirect_q  <= h_value;
    end
  end
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 16,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int OCC_W = TAG_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [1:0]        alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_value,
  input  logic              wb_exc,
  input  logic              wb_mispred,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_ready,
  output logic [DATA_W-1:0] lk_value,
  output logic              commit_reg_we,
  output logic              commit_mem_we,
  output logic              commit_retire,
  output logic [DEST_W-1:0] commit_dest,
  output logic [DATA_W-1:0] commit_data,
  output logic              flush,
  output logic              flush_exc,
  output logic [DATA_W-1:0] redirect_pc
);
  logic [TAG_W-1:0]  head_idx, tail_idx;
  logic [OCC_W-1:0]  occ;
  logic              full, pop, clear, alloc_fire, wb_we;
  logic              h_live, h_done, h_exc, h_mis;
  kind_e             h_kind;
  logic [DEST_W-1:0] h_dest;
  logic [DATA_W-1:0] h_value;

  assign alloc_ready = !full && !clear;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign wb_we       = wb_valid && !clear;
  assign alloc_tag   = tail_idx;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push(alloc_fire), .pop(pop), .clear(clear),
    .head_idx(head_idx), .tail_idx(tail_idx), .occ(occ), .full(full)
  );

  rob_entries #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_entries (
    .clk(clk), .rst(rst), .clear(clear),
    .alloc_we(alloc_fire), .alloc_idx(tail_idx),
    .alloc_kind(kind_e'(alloc_kind)), .alloc_dest(alloc_dest),
    .wb_we(wb_we), .wb_idx(wb_tag), .wb_value(wb_value),
    .wb_exc(wb_exc), .wb_mis(wb_mispred),
    .pop(pop), .head_idx(head_idx),
    .h_live(h_live), .h_done(h_done), .h_kind(h_kind), .h_dest(h_dest),
    .h_value(h_value), .h_exc(h_exc), .h_mis(h_mis),
    .lk_idx(lk_tag), .lk_ready_q(lk_ready), .lk_value_q(lk_value)
  );

  rob_retire #(.DATA_W(DATA_W), .DEST_W(DEST_W)) u_retire (
    .clk(clk), .rst(rst),
    .h_live(h_live), .h_done(h_done), .h_kind(h_kind), .h_dest(h_dest),
    .h_value(h_value), .h_exc(h_exc), .h_mis(h_mis),
    .pop(pop), .clear(clear),
    .reg_we_q(commit_reg_we), .mem_we_q(commit_mem_we), .retire_q(commit_retire),
    .dest_q(commit_dest), .data_q(commit_data),
    .flush_q(flush), .flush_exc_q(flush_exc), .redirect_q(redirect_pc)
  );
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int OCC_W = TAG_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic [OCC_W-1:0] occ,
  input logic             commit_reg_we,
  input logic             commit_mem_we,
  input logic             commit_retire,
  input logic             flush
);
  // R2: a full buffer refuses allocation
  a_r2_full_stalls: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_W'(DEPTH)) |-> !alloc_ready);

  // R2: occupancy never exceeds the slot count
  a_r2_occ_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH));

  // R5: at most one effect per cycle
  a_r5_single_effect: assert property (@(posedge clk) disable iff (rst)
    $onehot0({commit_reg_we, commit_mem_we, flush}));

  // R5: every write is a normal retirement
  a_r5_write_is_retire: assert property (@(posedge clk) disable iff (rst)
    (commit_reg_we || commit_mem_we) |-> commit_retire);

  // R6: a flush leaves the buffer empty
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |-> (occ == '0));

  // R1: tag numbering restarts after a flush
  a_r1_flush_restarts_tags: assert property (@(posedge clk) disable iff (rst)
    flush |-> (alloc_tag == '0));
endmodule

bind reorder_buffer rob_checker #(.DEPTH(DEPTH)) u_rob_chk (
  .clk(clk), .rst(rst), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
  .occ(occ), .commit_reg_we(commit_reg_we), .commit_mem_we(commit_mem_we),
  .commit_retire(commit_retire), .flush(flush)
);

// File: tb/reorder_buffer_test.sv
`timescale 1ns/1ps
module reorder_buffer_test;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int DEST_W = 16;
  localparam int TAG_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 1'b0;
  logic [1:0] alloc_kind = '0;
  logic [DEST_W-1:0] alloc_dest = '0;
  logic alloc_ready;
  logic [TAG_W-1:0] alloc_tag;
  logic wb_valid = 1'b0;
  logic [TAG_W-1:0] wb_tag = '0;
  logic [DATA_W-1:0] wb_value = '0;
  logic wb_exc = 1'b0, wb_mispred = 1'b0;
  logic [TAG_W-1:0] lk_tag = '0;
  logic lk_ready;
  logic [DATA_W-1:0] lk_value;
  logic commit_reg_we, commit_mem_we, commit_retire, flush, flush_exc;
  logic [DEST_W-1:0] commit_dest;
  logic [DATA_W-1:0] commit_data, redirect_pc;

  always #4 clk = ~clk;

  reorder_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) uut (.*);

  int n_chk = 0, n_fail = 0;

  // bench model of the buffer, indexed by tag
  logic              m_live [DEPTH];
  logic              m_done [DEPTH];
  logic [1:0]        m_kind [DEPTH];
  logic [DEST_W-1:0] m_dest [DEPTH];
  logic [DATA_W-1:0] m_val  [DEPTH];
  logic              m_exc  [DEPTH];
  logic              m_mis  [DEPTH];
  int m_head = 0, m_cnt = 0;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) begin
      m_live[i] = 1'b0; m_done[i] = 1'b0; m_exc[i] = 1'b0; m_mis[i] = 1'b0;
    end
    m_head = 0; m_cnt = 0;
  endtask

  // drive one cycle of inputs, step one edge, check against the model
  task automatic tick(input logic av, input logic [1:0] ak, input logic [DEST_W-1:0] ad,
                      input logic wv, input int wt, input logic [DATA_W-1:0] wval,
                      input logic we, input logic wm, input int lt);
    int h, tail_pre, lt_i;
    logic ev, bad, acc, e_lr;
    logic [DATA_W-1:0] e_lv;
    h = m_head;
    tail_pre = (m_head + m_cnt) % DEPTH;
    ev  = (m_cnt > 0) && m_done[h];
    bad = ev && (m_exc[h] || (m_kind[h] == 2'd2 && m_mis[h]));
    chk(alloc_ready == ((m_cnt < DEPTH) && !bad), "R2/R8 alloc_ready",
        64'(alloc_ready), 64'((m_cnt < DEPTH) && !bad));
    chk(alloc_tag == TAG_W'(tail_pre), "R1 alloc_tag", 64'(alloc_tag), 64'(tail_pre));
    acc = av && alloc_ready;
    alloc_valid = av; alloc_kind = ak; alloc_dest = ad;
    wb_valid = wv; wb_tag = TAG_W'(wt); wb_value = wval; wb_exc = we; wb_mispred = wm;
    lt_i = lt % DEPTH;
    lk_tag = TAG_W'(lt_i);
    e_lr = m_live[lt_i] && m_done[lt_i];
    e_lv = m_val[lt_i];
    if (wv && m_live[wt % DEPTH] && !m_done[wt % DEPTH]) begin
      m_done[wt % DEPTH] = 1'b1; m_val[wt % DEPTH] = wval;
      m_exc[wt % DEPTH] = we; m_mis[wt % DEPTH] = wm;
    end
    @(posedge clk); #2;
    chk((commit_retire || flush) == ev, "R4 retire timing", 64'(commit_retire || flush), 64'(ev));
    if (flush) begin
      chk(bad, "R6/R7 flush cause present", 64'(flush), 64'(bad));
      chk(flush_exc == m_exc[h], "R7 flush_exc", 64'(flush_exc), 64'(m_exc[h]));
      chk(redirect_pc == m_val[h], "R6 redirect_pc", 64'(redirect_pc), 64'(m_val[h]));
      chk(!commit_reg_we && !commit_mem_we, "R6/R7 no write on flush",
          64'({commit_reg_we, commit_mem_we}), 64'(0));
      model_clear();
    end else if (commit_retire) begin
      chk(!bad, "R6/R7 bad head retired", 64'(bad), 64'(0));
      chk(commit_reg_we == (m_kind[h] == 2'd0), "R5 reg_we", 64'(commit_reg_we), 64'(m_kind[h] == 2'd0));
      chk(commit_mem_we == (m_kind[h] == 2'd1), "R5 mem_we", 64'(commit_mem_we), 64'(m_kind[h] == 2'd1));
      if (commit_reg_we || commit_mem_we) begin
        chk(commit_dest == m_dest[h], "R5 commit_dest", 64'(commit_dest), 64'(m_dest[h]));
        chk(commit_data == m_val[h], "R3/R5 commit_data", 64'(commit_data), 64'(m_val[h]));
      end
      m_live[h] = 1'b0; m_done[h] = 1'b0;
      m_head = (m_head + 1) % DEPTH; m_cnt--;
    end
    if (acc) begin
      m_live[tail_pre] = 1'b1; m_done[tail_pre] = 1'b0; m_kind[tail_pre] = ak;
      m_dest[tail_pre] = ad; m_exc[tail_pre] = 1'b0; m_mis[tail_pre] = 1'b0;
      m_cnt++;
    end
    chk(lk_ready == e_lr, "R9 lk_ready", 64'(lk_ready), 64'(e_lr));
    if (e_lr) chk(lk_value == e_lv, "R9 lk_value", 64'(lk_value), 64'(e_lv));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 2'd0, '0, 1'b0, 0, '0, 1'b0, 1'b0, i);
  endtask

  task automatic alloc(input logic [1:0] k, input logic [DEST_W-1:0] d);
    tick(1'b1, k, d, 1'b0, 0, '0, 1'b0, 1'b0, 0);
  endtask

  task automatic wb(input int t, input logic [DATA_W-1:0] v, input logic e, input logic m);
    tick(1'b0, 2'd0, '0, 1'b1, t, v, e, m, t);
  endtask

  function automatic int pick_pending(input int start);
    for (int i = 0; i < DEPTH; i++) begin
      int t;
      t = (start + i) % DEPTH;
      if (m_live[t] && !m_done[t]) return t;
    end
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd20240611));
    model_clear();
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R10: reset state
    chk(alloc_ready == 1'b1, "R10 alloc_ready", 64'(alloc_ready), 64'(1));
    chk(alloc_tag == '0, "R10 alloc_tag", 64'(alloc_tag), 64'(0));
    chk(!commit_retire && !commit_reg_we && !commit_mem_we && !flush, "R10 no commit",
        64'({commit_retire, commit_reg_we, commit_mem_we, flush}), 64'(0));
    chk(lk_ready == 1'b0, "R10 lk_ready", 64'(lk_ready), 64'(0));

    // R2: fill past capacity, the extra request is refused
    for (int i = 0; i <= DEPTH; i++) alloc(2'd0, DEST_W'(16'h100 + i));
    chk(alloc_ready == 1'b0, "R2 full stall", 64'(alloc_ready), 64'(0));
    // R4: youngest finishes first and must wait
    wb(DEPTH - 1, 32'hA000_0007, 1'b0, 1'b0);
    idle(3);
    for (int t = DEPTH - 2; t >= 0; t--) wb(t, 32'hA000_0000 + t, 1'b0, 1'b0);
    idle(DEPTH + 2);

    // R6: mispredicted branch behind nothing, younger finished reg op dropped
    base = (m_head + m_cnt) % DEPTH;
    alloc(2'd2, 16'h0);
    alloc(2'd0, 16'h0011);
    wb((base + 1) % DEPTH, 32'h1234_5678, 1'b0, 1'b0);
    wb(base, 32'h0000_4000, 1'b0, 1'b1);
    idle(3);
    chk(alloc_tag == '0, "R1 tag restart", 64'(alloc_tag), 64'(0));

    // R7: correct branch retires, then excepting store flushes
    alloc(2'd2, 16'h0);
    alloc(2'd1, 16'h0BEE);
    alloc(2'd3, 16'h0);
    wb(1, 32'h0000_8000, 1'b1, 1'b0);
    wb(2, 32'h0000_0001, 1'b0, 1'b0);
    wb(0, 32'h0000_0200, 1'b0, 1'b0);
    idle(3);

    // R5: store and kind 3 normal retirement
    alloc(2'd1, 16'h0C00);
    alloc(2'd3, 16'h0);
    wb(0, 32'hDEAD_BEEF, 1'b0, 1'b0);
    wb(1, 32'h0, 1'b0, 1'b0);
    idle(3);

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      int t;
      logic [1:0] k;
      logic e, m;
      k = 2'($urandom_range(0, 3));
      t = pick_pending(int'($urandom_range(0, DEPTH - 1)));
      e = ($urandom_range(0, 39) == 0);
      m = ($urandom_range(0, 7) == 0);
      tick($urandom_range(0, 9) < 6, k, DEST_W'($urandom),
           (t >= 0) && ($urandom_range(0, 9) < 5), (t < 0) ? 0 : t, $urandom, e, m,
           int'($urandom_range(0, DEPTH - 1)));
    end
    // drain
    for (int c = 0; c < 4 * DEPTH; c++) begin
      int t;
      t = pick_pending(0);
      tick(1'b0, 2'd0, '0, t >= 0, (t < 0) ? 0 : t, $urandom, 1'b0, 1'b0, c);
    end
    chk(m_cnt == 0, "R4 drained", 64'(m_cnt), 64'(0));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule